// File: doc/BRIEF.md
# Store Buffer with Load Bypass and Forwarding

This block sits between a processor's load/store unit and a single-ported memory. Stores are captured in a small first-in first-out buffer and written to memory one per cycle, oldest first. Writes therefore keep their relative order, while reads are allowed to overtake them. A load whose address is not held in the buffer goes to memory at once, ahead of any older buffered stores. A load whose address is held in the buffer is answered from the buffer, taking the data of the most recent matching store, before that store has reached memory.

Two ordering controls are provided. A barrier pulse prevents any further store from entering until every store already in the buffer has drained. An atomic swap request waits until the buffer is empty and no read is outstanding. It then sends a single swap command to memory and returns the old memory word. Matching compares whole words only: stores always write a full word and addresses are word addresses.

Top module: `sbuf_top`

## Requirements
- R1: A load that matches no buffered entry is presented to memory in the cycle it is offered, even while older stores wait in the buffer, so the read reaches memory before those writes.
- R2: A load whose address equals a buffered entry's address is accepted without a memory request, and `ld_rsp_valid` rises one cycle after acceptance with the buffered data.
- R3: Stores are written to memory in exactly the order they were accepted, one write per accepted store, using `mem_req_op` codes 0 = read, 1 = write, 2 = swap.
- R4: After a `bar_valid` pulse, `st_ready` stays low until every store accepted before the pulse has been written to memory. A store accepted in the same cycle as the pulse counts as earlier.
- R5: An atomic swap is accepted only when the buffer is empty and no read is outstanding. It issues one swap command, and `rmw_rsp_data` returns the memory's previous word. While `rmw_valid` is high, no store or load is accepted.
- R6: The buffer holds DEPTH stores (default 4). When it is full, `st_ready` is low.
- R7: When several buffered entries share the load address, the forwarded data comes from the youngest of them.
- R8: After reset, the buffer is empty, `st_ready` is high, and `mem_req_valid`, `ld_rsp_valid` and `rmw_rsp_valid` are low.
- R9: While a read or swap waits for its memory response, no buffered store to that same address is written to memory.
- R10: A barrier pulse while the buffer is empty does not lower `st_ready`.
- R11: When a store and a load to the same address are accepted in the same cycle, the load is ordered first and does not see that store's data.
- R12: At most one read or swap is outstanding at memory. `ld_ready` is low until its response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load accepted this cycle when high with ld_valid |
| ld_addr | input | AW | Load word address |
| ld_rsp_valid | output | 1 | Load result valid, one-cycle pulse |
| ld_rsp_data | output | DW | Load result |
| bar_valid | input | 1 | Store barrier pulse |
| rmw_valid | input | 1 | Atomic swap offered |
| rmw_ready | output | 1 | Atomic swap accepted |
| rmw_addr | input | AW | Swap word address |
| rmw_data | input | DW | Value written by the swap |
| rmw_rsp_valid | output | 1 | Swap result valid, one-cycle pulse |
| rmw_rsp_data | output | DW | Previous memory word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_op | output | 2 | 0 read, 1 write, 2 swap |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Write or swap data |
| mem_rsp_valid | input | 1 | Read or swap response |
| mem_rsp_data | input | DW | Response data |

## Verification
The interesting collision is a load contending with the drain for the single memory port. The bench holds stores in the buffer with memory stalled, then releases memory in the same cycle that a missing load is offered. It judges the result from the memory's own log, where the read must come first. A second collision is a load and a store to the same address in one cycle. The load misses, goes to memory and stays outstanding, so the new store sits in the buffer. The memory model flags any write to that address before the read's response, and the scoreboard requires the load to return the old word.

// File: rtl/sbuf_pkg.sv
// Shared types for the store buffer: the memory command encoding.
package sbuf_pkg;
    typedef enum logic [1:0] {
        MOP_READ  = 2'd0,
        MOP_WRITE = 2'd1,
        MOP_SWAP  = 2'd2
    } mem_op_e;
endpackage

// File: rtl/sbuf_entries.sv
// Circular storage of buffered stores.
// Presents the entries rotated into age order (index 0 = oldest) so that the
// match logic needs no knowledge of the pointers.
// Assumes: pop is asserted only when cnt > 0, and push only when cnt < DEPTH
// or a pop happens in the same cycle.
module sbuf_entries #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [CW-1:0]                cnt,
    output logic [AW-1:0]                head_addr,
    output logic [DW-1:0]                head_data,
    output logic [DEPTH-1:0]             age_vld,
    output logic [DEPTH-1:0][AW-1:0]     age_addr,
    output logic [DEPTH-1:0][DW-1:0]     age_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][AW-1:0] addr_q;
    logic [DEPTH-1:0][DW-1:0] data_q;
    logic [PW-1:0]            head_q, tail_q;
    logic [CW-1:0]            cnt_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Capture store payload at the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail_q] <= push_addr;
            data_q[tail_q] <= push_data;
        end
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= ptr_inc(tail_q);
            if (pop)  head_q <= ptr_inc(head_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Rotate the storage into age order for the match logic.
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            int unsigned s;
            s = (int'(head_q) + k) % DEPTH;
            age_addr[k] = addr_q[s[PW-1:0]];
            age_data[k] = data_q[s[PW-1:0]];
            age_vld[k]  = (k < int'(cnt_q));
        end
    end

    assign cnt       = cnt_q;
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];
endmodule

// File: rtl/sbuf_match.sv
// Address match across the buffered entries.
// Scans oldest to youngest so that the last hit, the youngest one, wins.
// Assumes: inputs are in age order with index 0 the oldest.
module sbuf_match #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0]         age_vld,
    input  logic [DEPTH-1:0][AW-1:0] age_addr,
    input  logic [DEPTH-1:0][DW-1:0] age_data,
    input  logic [AW-1:0]            probe_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    logic [DEPTH-1:0] eq;

    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = age_vld[g] && (age_addr[g] == probe_addr);
    end

    // Youngest matching entry supplies the data.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (eq[k]) begin
                hit      = 1'b1;
                hit_data = age_data[k];
            end
        end
    end
endmodule

// File: rtl/sbuf_top.sv
// Store buffer between a processor and a single-ported memory.
// Stores drain in order. Loads bypass buffered stores to other addresses and
// forward from the youngest matching entry. A barrier pulse fences later
// stores, and an atomic swap waits for an empty buffer.
// Assumes: the memory answers every read and swap with exactly one
// mem_rsp_valid pulse at least one cycle after acceptance, and never answers
// writes. mem_req_ready does not depend on mem_req_valid.
module sbuf_top #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    input  logic          bar_valid,
    input  logic          rmw_valid,
    output logic          rmw_ready,
    input  logic [AW-1:0] rmw_addr,
    input  logic [DW-1:0] rmw_data,
    output logic          rmw_rsp_valid,
    output logic [DW-1:0] rmw_rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [1:0]    mem_req_op,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    import sbuf_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]            cnt_w, cnt_nx;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [DEPTH-1:0]         age_vld;
    logic [DEPTH-1:0][AW-1:0] age_addr;
    logic [DEPTH-1:0][DW-1:0] age_data;
    logic                     ld_hit;
    logic [DW-1:0]            fwd_data;

    logic                     fence_q;
    logic                     rd_busy_q, rd_rmw_q;
    logic [AW-1:0]            rd_addr_q;
    logic                     ld_rsp_valid_q, rmw_rsp_valid_q;
    logic [DW-1:0]            ld_rsp_data_q, rmw_rsp_data_q;

    logic buf_empty, buf_full;
    logic push, pop;
    logic load_req, drain_req, swap_req;
    logic ld_fire, ld_fire_miss, rmw_fire;
    logic drain_conflict;
    mem_op_e op_sel;

    sbuf_entries #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) entries_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .cnt       (cnt_w),
        .head_addr (head_addr),
        .head_data (head_data),
        .age_vld   (age_vld),
        .age_addr  (age_addr),
        .age_data  (age_data)
    );

    sbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) match_i (
        .age_vld    (age_vld),
        .age_addr   (age_addr),
        .age_data   (age_data),
        .probe_addr (ld_addr),
        .hit        (ld_hit),
        .hit_data   (fwd_data)
    );

    // Occupancy flags.
    assign buf_empty = (cnt_w == '0);
    assign buf_full  = (cnt_w == CW'(DEPTH));

    // Store side: blocked when full, fenced, or behind a waiting swap.
    assign st_ready = !buf_full && !fence_q && !rmw_valid;
    assign push     = st_valid && st_ready;

    // Load side: one outstanding read; a hit needs no memory slot.
    assign ld_ready     = !rd_busy_q && !rmw_valid && (ld_hit || mem_req_ready);
    assign ld_fire      = ld_valid && ld_ready;
    assign ld_fire_miss = ld_fire && !ld_hit;

    // Memory port requests: swap, then load miss, then drain.
    assign swap_req       = rmw_valid && buf_empty && !rd_busy_q;
    assign load_req       = ld_valid && !ld_hit && !rd_busy_q && !rmw_valid;
    assign drain_conflict = rd_busy_q && (rd_addr_q == head_addr);
    assign drain_req      = !buf_empty && !load_req && !drain_conflict;

    assign rmw_ready = swap_req && mem_req_ready;
    assign rmw_fire  = rmw_valid && rmw_ready;
    assign pop       = drain_req && mem_req_ready;

    // Select the memory command for this cycle.
    always_comb begin
        if (swap_req) begin
            op_sel        = MOP_SWAP;
            mem_req_addr  = rmw_addr;
            mem_req_wdata = rmw_data;
        end else if (load_req) begin
            op_sel        = MOP_READ;
            mem_req_addr  = ld_addr;
            mem_req_wdata = '0;
        end else begin
            op_sel        = MOP_WRITE;
            mem_req_addr  = head_addr;
            mem_req_wdata = head_data;
        end
    end

    assign mem_req_valid = swap_req || load_req || drain_req;
    assign mem_req_op    = op_sel;

    // Occupancy after this cycle's push and pop.
    assign cnt_nx = cnt_w + CW'(push) - CW'(pop);

    // Barrier: fence holds until the buffer has fully drained.
    always_ff @(posedge clk) begin
        if (!rst_n) fence_q <= 1'b0;
        else        fence_q <= (fence_q || bar_valid) && (cnt_nx != '0);
    end

    // Track the single outstanding read or swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy_q <= 1'b0;
            rd_rmw_q  <= 1'b0;
            rd_addr_q <= '0;
        end else if (ld_fire_miss || rmw_fire) begin
            rd_busy_q <= 1'b1;
            rd_rmw_q  <= rmw_fire;
            rd_addr_q <= rmw_fire ? rmw_addr : ld_addr;
        end else if (mem_rsp_valid) begin
            rd_busy_q <= 1'b0;
        end
    end

    // Register responses back to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_rsp_valid_q  <= 1'b0;
            rmw_rsp_valid_q <= 1'b0;
            ld_rsp_data_q   <= '0;
            rmw_rsp_data_q  <= '0;
        end else begin
            ld_rsp_valid_q  <= (ld_fire && ld_hit) ||
                               (mem_rsp_valid && rd_busy_q && !rd_rmw_q);
            rmw_rsp_valid_q <= mem_rsp_valid && rd_busy_q && rd_rmw_q;
            if (ld_fire && ld_hit)
                ld_rsp_data_q <= fwd_data;
            else if (mem_rsp_valid && rd_busy_q && !rd_rmw_q)
                ld_rsp_data_q <= mem_rsp_data;
            if (mem_rsp_valid && rd_busy_q && rd_rmw_q)
                rmw_rsp_data_q <= mem_rsp_data;
        end
    end

    assign ld_rsp_valid  = ld_rsp_valid_q;
    assign ld_rsp_data   = ld_rsp_data_q;
    assign rmw_rsp_valid = rmw_rsp_valid_q;
    assign rmw_rsp_data  = rmw_rsp_data_q;
endmodule

// File: rtl/sbuf_chk.sv
// Protocol checks for sbuf_top, attached through bind.
module sbuf_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_ready,
    input logic          ld_ready,
    input logic [CW-1:0] cnt,
    input logic          fence,
    input logic          rd_busy,
    input logic [AW-1:0] rd_addr,
    input logic          mem_req_valid,
    input logic [1:0]    mem_req_op,
    input logic [AW-1:0] mem_req_addr,
    input logic          ld_rsp_valid,
    input logic          rmw_rsp_valid
);
    a_r6_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> !st_ready);

    a_r4_fence_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fence |-> !st_ready);

    a_r5_swap_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == 2'd2) |-> (cnt == '0));

    a_r9_no_drain_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && mem_req_valid && mem_req_op == 2'd1) |-> (mem_req_addr != rd_addr));

    a_r12_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && mem_req_valid) |-> (mem_req_op == 2'd1));

    a_r12_load_held: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> !ld_ready);

    a_r3_no_op3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_op != 2'd3));

    a_r2_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_rsp_valid && rmw_rsp_valid));
endmodule

bind sbuf_top sbuf_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_ready      (st_ready),
    .ld_ready      (ld_ready),
    .cnt           (cnt_w),
    .fence         (fence_q),
    .rd_busy       (rd_busy_q),
    .rd_addr       (rd_addr_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_op    (mem_req_op),
    .mem_req_addr  (mem_req_addr),
    .ld_rsp_valid  (ld_rsp_valid),
    .rmw_rsp_valid (rmw_rsp_valid)
);

// File: tb/sbuf_top_tb_top.sv
`timescale 1ns/1ps
module sbuf_top_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          ld_valid = 1'b0, ld_ready;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_rsp_valid;
    logic [DW-1:0] ld_rsp_data;
    logic          bar_valid = 1'b0;
    logic          rmw_valid = 1'b0, rmw_ready;
    logic [AW-1:0] rmw_addr = '0;
    logic [DW-1:0] rmw_data = '0;
    logic          rmw_rsp_valid;
    logic [DW-1:0] rmw_rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [1:0]    mem_req_op;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    sbuf_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .bar_valid(bar_valid),
        .rmw_valid(rmw_valid), .rmw_ready(rmw_ready), .rmw_addr(rmw_addr), .rmw_data(rmw_data),
        .rmw_rsp_valid(rmw_rsp_valid), .rmw_rsp_data(rmw_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Program-order view of memory and scoreboard queues.
    logic [DW-1:0] arch [16];
    logic [DW-1:0] ld_exp_q [$];
    string         ld_tag_q [$];
    logic [DW-1:0] rmw_exp_q [$];
    logic [AW+DW-1:0] wr_exp_q [$];
    int            op_log [$];

    function automatic logic [DW-1:0] init_val(input int i);
        return 32'hC0DE_0000 + DW'(i);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: 2-cycle read latency, logs every accepted command.
    logic [DW-1:0] mem [16];
    logic          pend;
    int            lat;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
            pend <= 1'b0;
            lat  <= 0;
            mem_rsp_data <= '0;
        end else begin
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= pend_data;
                    pend <= 1'b0;
                end else lat <= lat - 1;
            end
            if (mem_req_valid && mem_req_ready) begin
                op_log.push_back(int'(mem_req_op));
                if (mem_req_op == 2'd1) begin
                    // R3: write order and content
                    if (wr_exp_q.size() == 0)
                        chk(0, "R3 unexpected write", longint'(mem_req_addr), 0);
                    else begin
                        logic [AW+DW-1:0] e;
                        e = wr_exp_q.pop_front();
                        chk(e == {mem_req_addr, mem_req_wdata}, "R3 write order",
                            longint'({mem_req_addr, mem_req_wdata}), longint'(e));
                    end
                    // R9: no write to the address of a pending read
                    if (pend && pend_addr == mem_req_addr)
                        chk(0, "R9 write during pending read", longint'(mem_req_addr), 0);
                    mem[mem_req_addr[3:0]] <= mem_req_wdata;
                end else begin
                    if (pend) chk(0, "R12 second read outstanding", 1, 0);
                    pend      <= 1'b1;
                    lat       <= 1;
                    pend_addr <= mem_req_addr;
                    pend_data <= mem[mem_req_addr[3:0]];
                    if (mem_req_op == 2'd2) mem[mem_req_addr[3:0]] <= mem_req_wdata;
                end
            end
        end
    end

    // Monitor: compares responses against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && ld_rsp_valid) begin
            if (ld_exp_q.size() == 0) chk(0, "R2 unexpected load response", longint'(ld_rsp_data), 0);
            else begin
                logic [DW-1:0] e;
                string t;
                e = ld_exp_q.pop_front();
                t = ld_tag_q.pop_front();
                chk(ld_rsp_data == e, t, longint'(ld_rsp_data), longint'(e));
            end
        end
        if (rst_n && rmw_rsp_valid) begin
            if (rmw_exp_q.size() == 0) chk(0, "R5 unexpected swap response", longint'(rmw_rsp_data), 0);
            else begin
                logic [DW-1:0] e;
                e = rmw_exp_q.pop_front();
                chk(rmw_rsp_data == e, "R5 swap old value", longint'(rmw_rsp_data), longint'(e));
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        wr_exp_q.push_back({a, d});
        arch[a[3:0]] = d;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        #1;
        while (!ld_ready) begin @(negedge clk); #1; end
        ld_exp_q.push_back(arch[a[3:0]]);
        ld_tag_q.push_back(tag);
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int l0;
        for (int i = 0; i < 16; i++) arch[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        chk(st_ready == 1'b1, "R8 st_ready", longint'(st_ready), 1);
        chk(mem_req_valid == 1'b0, "R8 mem_req_valid", longint'(mem_req_valid), 0);
        chk(ld_rsp_valid == 1'b0 && rmw_rsp_valid == 1'b0, "R8 responses idle",
            longint'({ld_rsp_valid, rmw_rsp_valid}), 0);

        // Fill with memory stalled; two entries share address 1.
        mem_req_ready = 1'b0;
        do_store(16'd1, 32'h1111_0001);
        do_store(16'd5, 32'h5555_0005);
        do_store(16'd1, 32'h1111_0002);
        do_store(16'd3, 32'h3333_0003);
        // R6: fifth store stalls
        @(negedge clk);
        st_valid = 1'b1; st_addr = 16'd8; st_data = 32'h8888_0008;
        #1;
        chk(st_ready == 1'b0, "R6 full stalls store", longint'(st_ready), 0);
        @(negedge clk);
        st_valid = 1'b0;

        // R7 youngest match, R2 plain forwarding, both without memory
        l0 = op_log.size();
        do_load(16'd1, "R7 youngest forward");
        do_load(16'd5, "R2 forward");
        idle(2);
        chk(op_log.size() == l0, "R2 no memory access on hit", op_log.size(), l0);

        // R1: miss offered in the cycle memory reopens; read goes first
        @(negedge clk);
        mem_req_ready = 1'b1;
        ld_valid = 1'b1; ld_addr = 16'd9;
        #1;
        chk(ld_ready == 1'b1, "R1 miss accepted with stores buffered", longint'(ld_ready), 1);
        ld_exp_q.push_back(arch[9]);
        ld_tag_q.push_back("R1 bypass data");
        @(posedge clk); #1;
        ld_valid = 1'b0;
        idle(10);
        chk(op_log.size() > l0 && op_log[l0] == 0, "R1 read before buffered writes",
            (op_log.size() > l0) ? op_log[l0] : -1, 0);
        chk(mem[1] == 32'h1111_0002 && mem[3] == 32'h3333_0003, "R3 final memory",
            longint'(mem[1]), longint'(32'h1111_0002));

        // R4: barrier with buffered stores
        mem_req_ready = 1'b0;
        do_store(16'd13, 32'hDDDD_000D);
        do_store(16'd14, 32'hEEEE_000E);
        @(negedge clk); bar_valid = 1'b1;
        @(negedge clk); bar_valid = 1'b0;
        st_valid = 1'b1; st_addr = 16'd15; st_data = 32'hFFFF_000F;
        begin
            bit any_ready;
            any_ready = 0;
            repeat (4) begin #1; if (st_ready) any_ready = 1; @(negedge clk); end
            chk(!any_ready, "R4 barrier holds stores", longint'(any_ready), 0);
        end
        mem_req_ready = 1'b1;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        chk(wr_exp_q.size() == 0, "R4 released only after drain", wr_exp_q.size(), 0);
        wr_exp_q.push_back({16'd15, 32'hFFFF_000F});
        arch[15] = 32'hFFFF_000F;
        @(posedge clk); #1;
        st_valid = 1'b0;
        idle(4);

        // R10: barrier on empty buffer
        @(negedge clk); bar_valid = 1'b1;
        @(negedge clk); bar_valid = 1'b0;
        #1;
        chk(st_ready == 1'b1, "R10 empty barrier no stall", longint'(st_ready), 1);

        // R5: swap waits for drain, returns old word
        mem_req_ready = 1'b0;
        do_store(16'd7, 32'h7777_0007);
        do_store(16'd6, 32'h6666_0006);
        @(negedge clk);
        rmw_valid = 1'b1; rmw_addr = 16'd7; rmw_data = 32'hABCD_0007;
        #1;
        chk(rmw_ready == 1'b0 && st_ready == 1'b0 && ld_ready == 1'b0,
            "R5 swap waits, stores and loads held",
            longint'({rmw_ready, st_ready, ld_ready}), 0);
        @(negedge clk);
        mem_req_ready = 1'b1;
        #1;
        while (!rmw_ready) begin @(negedge clk); #1; end
        chk(wr_exp_q.size() == 0, "R5 swap after drain", wr_exp_q.size(), 0);
        rmw_exp_q.push_back(arch[7]);
        arch[7] = 32'hABCD_0007;
        @(posedge clk); #1;
        rmw_valid = 1'b0;
        idle(5);
        chk(op_log[op_log.size()-1] == 2, "R5 swap command code", op_log[op_log.size()-1], 2);
        do_load(16'd7, "R5 load after swap");
        idle(5);

        // R9 and R12: store to the address of an outstanding read
        do_load(16'd11, "R9 load keeps old value");
        #1;
        chk(ld_ready == 1'b0, "R12 load held while read outstanding", longint'(ld_ready), 0);
        do_store(16'd11, 32'hBBBB_000B);
        idle(8);
        chk(mem[11] == 32'hBBBB_000B, "R9 store drains after response",
            longint'(mem[11]), longint'(32'hBBBB_000B));

        // R11: store and load to one address in the same cycle
        @(negedge clk);
        st_valid = 1'b1; st_addr = 16'd12; st_data = 32'hCCCC_000C;
        ld_valid = 1'b1; ld_addr = 16'd12;
        #1;
        chk(st_ready && ld_ready, "R11 both accepted", longint'({st_ready, ld_ready}), 3);
        ld_exp_q.push_back(arch[12]);
        ld_tag_q.push_back("R11 load ordered before store");
        wr_exp_q.push_back({16'd12, 32'hCCCC_000C});
        arch[12] = 32'hCCCC_000C;
        @(posedge clk); #1;
        st_valid = 1'b0; ld_valid = 1'b0;
        idle(10);
        do_load(16'd12, "R11 later load sees store");
        idle(6);

        chk(ld_exp_q.size() == 0 && rmw_exp_q.size() == 0 && wr_exp_q.size() == 0,
            "R3 scoreboard drained", ld_exp_q.size() + rmw_exp_q.size() + wr_exp_q.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule